// File: doc/BRIEF.md
# EDO Page-Mode DRAM Sequencer

This block turns single-beat requests from a synchronous requester into strobe sequences for an asynchronous EDO DRAM with a byte-wide data bus. Each request carries a row, a column, a read/write flag, write data and a hint that the next access is likely to use the same row. The sequencer drives the row on the shared address pins and lowers RAS. After the RAS-to-CAS delay it drives the column and pulses CAS. When the hint is set it keeps RAS low, so that later requests to the same row only need a CAS pulse.

Every timing is a parameter counted in clock cycles. Writes use early-write timing: WE and the data driver are active only while CAS is low, and OE stays high. Reads hold OE low through the CAS pulse and the CAS precharge phase that follows. Because the EDO output keeps its value after CAS rises, the data is captured at the end of the precharge phase and returned with a one-cycle valid pulse.

A row stays open only within a cycle budget below the maximum RAS-low time. A request to another row, a cleared hint, an expired budget or a refresh request closes the row. A refresh block asks for the bus with a request line. It gets a grant once both strobes are high, and RAS precharge is enforced after it lets go.

Top module: `edo_page_seq`

## Requirements
- R1: Out of reset, RAS, CAS, WE and OE are high, the data driver is off, no grant or read-valid is given, and a request is accepted (ready high).
- R2: RAS stays high for at least T_RP cycles before each fall and stays low for at least T_RAS cycles once it falls.
- R3: CAS falls only while RAS is low, at least T_RCD cycles after RAS fell, with the column on the address pins (row in the low address bits before that). CAS stays low for at least T_CAS cycles and high for at least T_CP cycles between pulses.
- R4: A write drives WE low and enables the data driver only in cycles where CAS is low, and keeps OE high throughout.
- R5: A read holds OE low with WE high and the driver off. The byte returned with the one-cycle rd_valid_o pulse equals the last byte written to that row and column.
- R6: With the hint set, a following request to the same row is served by a CAS pulse alone, with no new RAS fall.
- R7: A request to a different row, or any request after one made with the hint clear, starts a new RAS cycle.
- R8: RAS is never low for more than T_RASMAX cycles; an open row with no traffic, or a long run of hits, is closed within that limit.
- R9: A refresh request closes any open row. The grant is given only while RAS and CAS are high, and no request is accepted while it is held. RAS precharge is enforced after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_row_i | input | ROW_W | Row of the request |
| req_col_i | input | COL_W | Column of the request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DQ_W | Write byte |
| req_keep_i | input | 1 | Hint: keep the row open after this access |
| rd_valid_o | output | 1 | One-cycle pulse with read data |
| rd_data_o | output | DQ_W | Read byte |
| ref_req_i | input | 1 | Refresh block asks for the bus |
| ref_gnt_o | output | 1 | Bus handed to the refresh block |
| dram_addr_o | output | max(ROW_W,COL_W) | Multiplexed address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_dq_o | output | DQ_W | Write data to the DRAM |
| dram_dq_oe_o | output | 1 | Data driver enable |
| dram_dq_i | input | DQ_W | Read data from the DRAM |

## Verification
A behavioural EDO model in the bench holds its output from one CAS fall to the next, so a sample taken in the wrong phase returns a stale byte. The whole cell array is first written row by row with the hint set and read back the same way; only one RAS fall per row is expected. It is then rewritten column by column, which makes every access a row miss, and read back with the hint clear, where every access must open its own row. Alternating writes and reads inside one page show that CAS-only accesses write and read correctly. A long run of hits and an idle open row test the open-time limit. A refresh request made while a row is open must produce a close, a grant with both strobes high, and a correct read afterwards.

// File: rtl/edo_seq_pkg.sv
`timescale 1ns/1ps
package edo_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_COL, ST_CP, ST_OPEN, ST_CLOSE, ST_PRE, ST_REF
  } seq_st_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/edo_cyc_timer.sv
`timescale 1ns/1ps
module edo_cyc_timer #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/edo_row_track.sv
`timescale 1ns/1ps
module edo_row_track #(
  parameter int unsigned ROW_W    = 11,
  parameter int unsigned T_RAS    = 5,
  parameter int unsigned T_RASMAX = 9990,
  parameter int unsigned T_TAIL   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             ras_low_i,
  input  logic [ROW_W-1:0] cmp_row_i,
  output logic [ROW_W-1:0] row_o,
  output logic             hit_o,
  output logic             min_ok_o,
  output logic             expired_o
);
  localparam int unsigned RT_W  = $clog2(T_RASMAX + 1);
  localparam int unsigned LIMIT = T_RASMAX - T_TAIL;
  localparam logic [RT_W-1:0] LIM_C = RT_W'(LIMIT);
  localparam logic [RT_W-1:0] MIN_C = RT_W'(T_RAS - 1);
  localparam logic [RT_W-1:0] MAX_C = RT_W'(T_RASMAX);

  logic [ROW_W-1:0] row_q;
  logic [RT_W-1:0]  low_q;  // completed RAS-low cycles

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      low_q <= '0;
    end else if (capture_i) begin
      row_q <= row_i;
      low_q <= '0;
    end else if (ras_low_i && low_q != MAX_C) begin
      low_q <= low_q + 1'b1;
    end
  end

  assign row_o     = row_q;
  assign hit_o     = (cmp_row_i == row_q);
  assign min_ok_o  = (low_q >= MIN_C);
  assign expired_o = (low_q >= LIM_C);

  a_r8_open_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_low_i |-> (low_q < MAX_C));
endmodule

// File: rtl/edo_page_seq.sv
`timescale 1ns/1ps
module edo_page_seq
  import edo_seq_pkg::*;
#(
  parameter int unsigned ROW_W    = 11,
  parameter int unsigned COL_W    = 10,
  parameter int unsigned DQ_W     = 8,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_RAS    = 5,
  parameter int unsigned T_RCD    = 2,
  parameter int unsigned T_CAS    = 1,
  parameter int unsigned T_CP     = 1,
  parameter int unsigned T_RASMAX = 9990
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_valid_i,
  output logic                              req_ready_o,
  input  logic [ROW_W-1:0]                  req_row_i,
  input  logic [COL_W-1:0]                  req_col_i,
  input  logic                              req_we_i,
  input  logic [DQ_W-1:0]                   req_wdata_i,
  input  logic                              req_keep_i,
  output logic                              rd_valid_o,
  output logic [DQ_W-1:0]                   rd_data_o,
  input  logic                              ref_req_i,
  output logic                              ref_gnt_o,
  output logic [max_u(ROW_W, COL_W)-1:0]    dram_addr_o,
  output logic                              dram_ras_no,
  output logic                              dram_cas_no,
  output logic                              dram_we_no,
  output logic                              dram_oe_no,
  output logic [DQ_W-1:0]                   dram_dq_o,
  output logic                              dram_dq_oe_o,
  input  logic [DQ_W-1:0]                   dram_dq_i
);
  localparam int unsigned A_W    = max_u(ROW_W, COL_W);
  localparam int unsigned TW     = $clog2(max_u(max_u(T_RP, T_RCD), max_u(T_CAS, T_CP)) + 1);
  localparam int unsigned T_TAIL = T_CAS + T_CP + 1;
  localparam int unsigned HW     = $clog2(T_RP + 1);
  localparam int unsigned LW     = $clog2(T_RAS + 1);

  seq_st_e st_q, st_d;
  logic            tmr_ld, tmr_done;
  logic [TW-1:0]   tmr_val;
  logic            acc, smp;
  logic            hit, min_ok, expired;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic            we_q, keep_q;
  logic [DQ_W-1:0] wd_q;

  edo_cyc_timer #(.W(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_ld),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  edo_row_track #(
    .ROW_W(ROW_W), .T_RAS(T_RAS), .T_RASMAX(T_RASMAX), .T_TAIL(T_TAIL)
  ) u_row (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (acc && st_q == ST_IDLE),
    .row_i     (req_row_i),
    .ras_low_i (!dram_ras_no),
    .cmp_row_i (req_row_i),
    .row_o     (row_q),
    .hit_o     (hit),
    .min_ok_o  (min_ok),
    .expired_o (expired)
  );

  always_comb begin
    st_d    = st_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    acc     = 1'b0;
    smp     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_req_i) st_d = ST_REF;
        else if (req_valid_i) begin
          acc = 1'b1; st_d = ST_ACT; tmr_ld = 1'b1; tmr_val = TW'(T_RCD - 1);
        end
      end
      ST_ACT: if (tmr_done) begin
        st_d = ST_COL; tmr_ld = 1'b1; tmr_val = TW'(T_CAS - 1);
      end
      ST_COL: if (tmr_done) begin
        st_d = ST_CP; tmr_ld = 1'b1; tmr_val = TW'(T_CP - 1);
      end
      ST_CP: if (tmr_done) begin
        smp  = !we_q;  // EDO output still held after CAS rise
        st_d = (keep_q && !ref_req_i && !expired) ? ST_OPEN : ST_CLOSE;
      end
      ST_OPEN: begin
        if (ref_req_i || expired) st_d = ST_CLOSE;
        else if (req_valid_i) begin
          if (hit) begin
            acc = 1'b1; st_d = ST_COL; tmr_ld = 1'b1; tmr_val = TW'(T_CAS - 1);
          end else st_d = ST_CLOSE;
        end
      end
      ST_CLOSE: if (min_ok) begin
        st_d = ST_PRE; tmr_ld = 1'b1; tmr_val = TW'(T_RP - 1);
      end
      ST_PRE: if (tmr_done) st_d = ST_IDLE;
      ST_REF: if (!ref_req_i) begin
        st_d = ST_PRE; tmr_ld = 1'b1; tmr_val = TW'(T_RP - 1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      col_q      <= '0;
      we_q       <= 1'b0;
      keep_q     <= 1'b0;
      wd_q       <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      st_q       <= st_d;
      rd_valid_o <= smp;
      if (smp) rd_data_o <= dram_dq_i;
      if (acc) begin
        col_q  <= req_col_i;
        we_q   <= req_we_i;
        keep_q <= req_keep_i;
        wd_q   <= req_wdata_i;
      end
    end
  end

  assign req_ready_o  = !ref_req_i &&
                        ((st_q == ST_IDLE) || (st_q == ST_OPEN && !expired && hit));
  assign ref_gnt_o    = (st_q == ST_REF);
  assign dram_ras_no  = (st_q == ST_IDLE) || (st_q == ST_PRE) || (st_q == ST_REF);
  assign dram_cas_no  = (st_q != ST_COL);
  assign dram_we_no   = !(st_q == ST_COL && we_q);
  assign dram_dq_oe_o = (st_q == ST_COL) && we_q;
  assign dram_oe_no   = !((st_q == ST_COL || st_q == ST_CP) && !we_q);
  assign dram_dq_o    = wd_q;
  assign dram_addr_o  = (st_q == ST_ACT) ? A_W'(row_q) : A_W'(col_q);

  // strobe-width history for the checks below
  logic          ras_n_q;
  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_n_q <= 1'b1;
      hi_cnt  <= HW'(T_RP);
      lo_cnt  <= '0;
    end else begin
      ras_n_q <= dram_ras_no;
      if (dram_ras_no) begin
        lo_cnt <= '0;
        if (hi_cnt != HW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != LW'(T_RAS)) lo_cnt <= lo_cnt + 1'b1;
      end
    end
  end

  a_r2_ras_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_n_q && !dram_ras_no) |-> (hi_cnt >= HW'(T_RP)));
  a_r2_ras_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_q && dram_ras_no) |-> (lo_cnt >= LW'(T_RAS)));
  a_r3_cas_in_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no |-> !dram_ras_no);
  a_r4_early_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_we_no |-> (!dram_cas_no && dram_dq_oe_o && dram_oe_no));
  a_r5_oe_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_oe_no |-> (dram_we_no && !dram_dq_oe_o));
  a_r5_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
  a_r9_grant_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_gnt_o |-> (dram_ras_no && dram_cas_no && !req_ready_o));
endmodule

// File: tb/sim_edo_page_seq.sv
`timescale 1ns/1ps
module sim_edo_page_seq;
  localparam int RW = 3, CW = 3, DW = 8;
  localparam int TRP = 3, TRAS = 5, TRCD = 2, TCAS = 1, TCP = 1, TMAX = 40;
  localparam int NR = 1 << RW, NC = 1 << CW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_we = 1'b0, req_keep = 1'b0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rd_valid, ref_req = 1'b0, ref_gnt;
  logic [DW-1:0] rd_data;
  logic [2:0] addr;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] dq_o, drv = '0;

  edo_page_seq #(
    .ROW_W(RW), .COL_W(CW), .DQ_W(DW), .T_RP(TRP), .T_RAS(TRAS), .T_RCD(TRCD),
    .T_CAS(TCAS), .T_CP(TCP), .T_RASMAX(TMAX)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_row_i(req_row),
    .req_col_i(req_col), .req_we_i(req_we), .req_wdata_i(req_wdata), .req_keep_i(req_keep),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .ref_req_i(ref_req), .ref_gnt_o(ref_gnt),
    .dram_addr_o(addr), .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n),
    .dram_oe_no(oe_n), .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(drv)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int r, input int c, input int p);
    return 8'(r * 29 + c * 7 + p * 53 + 5);
  endfunction

  logic [DW-1:0] mem [NR*NC];
  logic [DW-1:0] gold [NR*NC];
  logic [DW-1:0] exp_q [$];
  bit mon_en = 1'b0, p_ras = 1'b1, p_cas = 1'b1;
  int mrow = 0, hi_len = TRP, lo_len = 0, cas_lo = 0, cas_hi = TCP, ras_falls = 0;

  // DRAM model and strobe monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (p_ras && !ras_n) begin
        chk(hi_len >= TRP, "R2 ras precharge", hi_len, TRP);
        ras_falls++; mrow = int'(addr); lo_len = 1;
      end else if (!p_ras && ras_n) begin
        chk(lo_len >= TRAS, "R2 ras low width", lo_len, TRAS);
        chk(lo_len <= TMAX, "R8 ras open limit", lo_len, TMAX);
        hi_len = 1;
      end else if (ras_n) hi_len++;
      else lo_len++;

      if (p_cas && !cas_n) begin
        chk(!ras_n, "R3 cas under ras", int'(ras_n), 0);
        chk(lo_len - 1 >= TRCD, "R3 ras to cas", lo_len - 1, TRCD);
        chk(cas_hi >= TCP, "R3 cas precharge", cas_hi, TCP);
        if (!we_n) begin
          chk(dq_oe && oe_n, "R4 early write bus", int'(dq_oe && oe_n), 1);
          mem[mrow*NC + int'(addr)] = dq_o;
        end else begin
          chk(!oe_n && !dq_oe, "R5 read oe", int'(!oe_n && !dq_oe), 1);
          drv = mem[mrow*NC + int'(addr)];
        end
        cas_lo = 1;
      end else if (!p_cas && cas_n) begin
        chk(cas_lo >= TCAS, "R3 cas low width", cas_lo, TCAS);
        cas_hi = 1;
      end else if (cas_n) cas_hi++;
      else cas_lo++;

      if (!we_n && cas_n) chk(1'b0, "R4 we outside cas", 0, 1);
      if (dq_oe && cas_n) chk(1'b0, "R4 driver outside cas", 0, 1);

      if (rd_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected read valid", 1, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R5 read data", int'(rd_data), int'(e));
        end
      end
      p_ras = ras_n; p_cas = cas_n;
    end
  end

  task automatic send(input int r, input int c, input bit we, input logic [7:0] d, input bit keep);
    @(negedge clk);
    req_valid = 1'b1; req_row = RW'(r); req_col = CW'(c);
    req_we = we; req_wdata = d; req_keep = keep;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (we) gold[r*NC + c] = d;
    else exp_q.push_back(gold[r*NC + c]);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int f0;
    for (int i = 0; i < NR*NC; i++) begin mem[i] = '0; gold[i] = '0; end
    idle(3);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes high", int'({ras_n, cas_n, we_n, oe_n}), 15);
    chk(!dq_oe && !ref_gnt && !rd_valid, "R1 outputs idle", int'({dq_oe, ref_gnt, rd_valid}), 0);
    chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
    mon_en = 1'b1;

    // row-major writes with hint: one RAS fall per row
    f0 = ras_falls;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) send(r, c, 1'b1, pat(r, c, 0), 1'b1);
    idle(15);
    chk(ras_falls - f0 == NR, "R6 page writes ras falls", ras_falls - f0, NR);

    f0 = ras_falls;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) send(r, c, 1'b0, 8'h00, 1'b1);
    idle(15);
    chk(ras_falls - f0 == NR, "R6 page reads ras falls", ras_falls - f0, NR);

    // column-major: every access misses the open row
    f0 = ras_falls;
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++) send(r, c, 1'b1, pat(r, c, 1), 1'b1);
    idle(15);
    chk(ras_falls - f0 == NR*NC, "R7 row miss ras falls", ras_falls - f0, NR*NC);

    // hint clear: each access is its own row cycle
    f0 = ras_falls;
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) send(r, c, 1'b0, 8'h00, 1'b0);
    idle(15);
    chk(ras_falls - f0 == NR*NC, "R7 hint clear ras falls", ras_falls - f0, NR*NC);

    // mixed writes and reads inside one page
    f0 = ras_falls;
    for (int c = 0; c < 4; c++) begin
      send(2, c, 1'b1, pat(2, c, 2), 1'b1);
      send(2, c, 1'b0, 8'h00, 1'b1);
    end
    idle(15);
    chk(ras_falls - f0 == 1, "R6 mixed page ras falls", ras_falls - f0, 1);

    // idle open row is closed by the time limit
    f0 = ras_falls;
    send(6, 3, 1'b0, 8'h00, 1'b1);
    idle(60);
    chk(ras_n == 1'b1, "R8 idle row closed", int'(ras_n), 1);
    chk(ras_falls - f0 == 1, "R8 idle single open", ras_falls - f0, 1);

    // long hit run must be split by the limit
    f0 = ras_falls;
    for (int k = 0; k < 30; k++) send(3, k % NC, 1'b0, 8'h00, 1'b1);
    idle(15);
    chk(ras_falls - f0 >= 2, "R8 long run reopened", ras_falls - f0, 2);

    // refresh while a row is open
    send(5, 1, 1'b0, 8'h00, 1'b1);
    idle(2);
    @(negedge clk); ref_req = 1'b1;
    begin
      int w;
      w = 0;
      while (!ref_gnt && w < 30) begin @(negedge clk); w++; end
      chk(ref_gnt, "R9 grant given", int'(ref_gnt), 1);
    end
    req_valid = 1'b1; req_row = 3'd5; req_col = 3'd2; req_we = 1'b0; req_keep = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      chk(ras_n && cas_n, "R9 strobes high in grant", int'({ras_n, cas_n}), 3);
      chk(!req_ready, "R9 no accept in grant", int'(req_ready), 0);
    end
    req_valid = 1'b0;
    @(negedge clk); ref_req = 1'b0;
    send(5, 2, 1'b0, 8'h00, 1'b0);
    send(0, 0, 1'b0, 8'h00, 1'b0);
    idle(20);
    chk(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule